// File: doc/BRIEF.md
# Battery-Backed RAM Chip-Enable Gate with Write Completion

This block sits between a processor or address decoder and a battery-backed static RAM and controls the active-low chip-enable strobe going to the RAM. While the system supervisor reports that reset is not asserted, the strobe passes straight through with no clock latency. When reset is asserted, the gate closes so that a processor running on a failing supply cannot corrupt the RAM contents.

A write can already be under way when reset asserts. In that case the gate stays open for a bounded completion window, `WINDOW_TICKS` clock cycles long. The window ends early when the processor ends the access by raising the strobe. Once the gate has closed, it latches shut and ignores all strobe activity until the supervisor releases reset. A power-on reset also starts the gate shut, so the RAM sees no strobe during power-up.

The default window is 4500 cycles, which is 18 µs at 250 MHz. `WINDOW_TICKS` must be at least 1.

Top module: `ce_write_gate`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first clock edge that samples `sys_rst_active` low, `gate_en` is 0 and `ce_out_n` is 1, whatever `ce_in_n` does.
- R2: While the gate is open (`gate_en` = 1), `ce_out_n` equals `ce_in_n` in the same cycle, with no added clock latency.
- R3: When a clock edge samples `sys_rst_active` = 1 and `ce_in_n` = 0 while the gate is open and no window is running, a completion window starts. During the window `gate_en` stays 1 while `ce_in_n` stays low, and `gate_en` is 1 for exactly `WINDOW_TICKS` cycles after that edge.
- R4: If `ce_in_n` goes high during the completion window, `ce_out_n` goes high in the same cycle and `gate_en` falls at the next clock edge.
- R5: If `ce_in_n` is still low when the window runs out, the gate closes at the `WINDOW_TICKS`-th edge after the window started, and `ce_out_n` goes high.
- R6: While the gate is closed and `sys_rst_active` is 1, `ce_out_n` stays 1 and `gate_en` stays 0, even when `ce_in_n` falls low again.
- R7: When a clock edge samples `sys_rst_active` = 1 while the gate is open and `ce_in_n` = 1, the gate closes at that same edge and no completion window is granted.
- R8: The first clock edge that samples `sys_rst_active` = 0 opens the gate (`gate_en` = 1). After that, `ce_out_n` is low only while `ce_in_n` is low.
- R9: If `sys_rst_active` is released during a completion window, the gate stays open and does not close when the window would have expired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all gate state changes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset; forces the gate closed |
| ce_in_n | input | 1 | Active-low chip-enable from the processor or address decoder |
| sys_rst_active | input | 1 | High while the system supervisor holds reset asserted |
| ce_out_n | output | 1 | Active-low chip-enable to the RAM |
| gate_en | output | 1 | High while the gate passes the chip-enable through |

## Verification
The bound checker examines every cycle for the following:
- the pass-through relation while the gate is open;
- the forced-high output while it is closed;
- that a closed gate stays closed while reset is held;
- that a raised strobe closes the gate at the next edge;
- that the gate always opens after reset is released;
- an upper bound on how long the gate can stay open under reset.

Three properties can only be shown by the bench scenarios, which drive the strobe edges at the right moments:
- the exact window length;
- early termination of the window;
- a window cut short by reset release.

The bench also runs a long random mix of strobe and reset activity against a bench-side model of the gate.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
    // Gate states: closed, open with reset released, open inside a completion window
    typedef enum logic [1:0] {
        GATE_SHUT = 2'd0,
        GATE_OPEN = 2'd1,
        GATE_HOLD = 2'd2
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
    } fsm_regs_s;
endpackage

// File: rtl/ceg_window_timer.sv
module ceg_window_timer #(
    parameter int WINDOW_TICKS = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic done
);
    localparam int CNT_W = (WINDOW_TICKS < 2) ? 1 : $clog2(WINDOW_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_s;

    tmr_regs_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = '0;
        end else if (advance) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = (tmr_q.cnt == LAST);
endmodule

// File: rtl/ceg_gate_fsm.sv
module ceg_gate_fsm
    import ceg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst_active,
    input  logic ce_in_n,
    input  logic window_done,
    output logic tmr_load,
    output logic tmr_advance,
    output logic gate_open
);
    fsm_regs_s fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        tmr_load    = 1'b0;
        tmr_advance = 1'b0;
        unique case (fsm_q.state)
            GATE_OPEN: begin
                if (sys_rst_active) begin
                    if (!ce_in_n) begin
                        // access in flight: grant the completion window
                        fsm_d.state = GATE_HOLD;
                        tmr_load    = 1'b1;
                    end else begin
                        fsm_d.state = GATE_SHUT;
                    end
                end
            end
            GATE_HOLD: begin
                if (!sys_rst_active) begin
                    fsm_d.state = GATE_OPEN;
                end else if (ce_in_n || window_done) begin
                    fsm_d.state = GATE_SHUT;
                end else begin
                    tmr_advance = 1'b1;
                end
            end
            GATE_SHUT: begin
                if (!sys_rst_active) begin
                    fsm_d.state = GATE_OPEN;
                end
            end
            default: fsm_d.state = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= GATE_SHUT;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign gate_open = (fsm_q.state != GATE_SHUT);
endmodule

// File: rtl/ceg_ce_path.sv
module ceg_ce_path (
    input  logic gate_open,
    input  logic ce_in_n,
    output logic ce_out_n
);
    // open gate: pure pass-through; closed gate: strobe held inactive
    always_comb begin
        ce_out_n = gate_open ? ce_in_n : 1'b1;
    end
endmodule

// File: rtl/ce_write_gate.sv
module ce_write_gate #(
    parameter int WINDOW_TICKS = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic sys_rst_active,
    output logic ce_out_n,
    output logic gate_en
);
    logic tmr_load;
    logic tmr_advance;
    logic window_done;
    logic gate_open;

    ceg_window_timer #(
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .advance (tmr_advance),
        .done    (window_done)
    );

    ceg_gate_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_rst_active (sys_rst_active),
        .ce_in_n        (ce_in_n),
        .window_done    (window_done),
        .tmr_load       (tmr_load),
        .tmr_advance    (tmr_advance),
        .gate_open      (gate_open)
    );

    ceg_ce_path u_path (
        .gate_open (gate_open),
        .ce_in_n   (ce_in_n),
        .ce_out_n  (ce_out_n)
    );

    assign gate_en = gate_open;
endmodule

// File: rtl/ce_write_gate_chk.sv
module ce_write_gate_chk #(
    parameter int WINDOW_TICKS = 4500
) (
    input logic clk,
    input logic rst_n,
    input logic ce_in_n,
    input logic sys_rst_active,
    input logic ce_out_n,
    input logic gate_en
);
    // consecutive edges sampled with the gate open while reset is asserted
    int open_under_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_under_rst <= 0;
        end else if (gate_en && sys_rst_active) begin
            open_under_rst <= open_under_rst + 1;
        end else begin
            open_under_rst <= 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_POR_SHUT: assert (!gate_en && ce_out_n); // R1
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (ce_out_n == ce_in_n)); // R2

    AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        open_under_rst <= WINDOW_TICKS + 1); // R5

    AST_HIGH_CE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && sys_rst_active && ce_in_n) |=> !gate_en); // R4

    AST_SHUT_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> ce_out_n); // R6

    AST_NO_REOPEN_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && sys_rst_active) |=> !gate_en); // R6

    AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_active |=> gate_en); // R8
endmodule

bind ce_write_gate ce_write_gate_chk #(
    .WINDOW_TICKS(WINDOW_TICKS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_in_n        (ce_in_n),
    .sys_rst_active (sys_rst_active),
    .ce_out_n       (ce_out_n),
    .gate_en        (gate_en)
);

// File: tb/ce_write_gate_test.sv
module ce_write_gate_test;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_in_n = 1'b0;
    logic sys_rst_active = 1'b1;
    logic ce_out_n;
    logic gate_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ce_write_gate #(.WINDOW_TICKS(W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ce_in_n        (ce_in_n),
        .sys_rst_active (sys_rst_active),
        .ce_out_n       (ce_out_n),
        .gate_en        (gate_en)
    );

    always #2 clk = ~clk;

    // bench model from the requirements: 0 closed, 1 open, 2 window running
    int m_mode = 0;
    int m_left = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0;
            m_left = 0;
        end else if (!sys_rst_active) begin
            m_mode = 1;
        end else if (m_mode == 1) begin
            if (!ce_in_n) begin
                m_mode = 2;
                m_left = W;
            end else begin
                m_mode = 0;
            end
        end else if (m_mode == 2) begin
            if (ce_in_n || m_left == 1) m_mode = 0;
            else m_left = m_left - 1;
        end
    end

    function automatic logic exp_gate();
        return (m_mode != 0);
    endfunction

    function automatic logic exp_out(input logic ce);
        return (m_mode != 0) ? ce : 1'b1;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic rst_v, input logic ce_v);
        @(negedge clk);
        sys_rst_active = rst_v;
        ce_in_n = ce_v;
        #1;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1: power-on reset, supervisor still in reset
        #1;
        check("R1 gate_en in por", gate_en, 1'b0);
        check("R1 ce_out_n in por", ce_out_n, 1'b1);
        step(1'b1, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(1'b1, logic'(i % 2));
            check("R1 power-up gate_en", gate_en, 1'b0);
            check("R1 power-up ce_out_n", ce_out_n, 1'b1);
        end

        // R8: release opens the gate; R2 pass-through
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R8 gate_en after release", gate_en, 1'b1);
        check("R8 ce_out_n high with input high", ce_out_n, 1'b1);
        step(1'b0, 1'b0);
        check("R2 ce_out_n follows low", ce_out_n, 1'b0);
        step(1'b0, 1'b1);
        check("R2 ce_out_n follows high", ce_out_n, 1'b1);

        // R3/R5: window length with the strobe held low
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        cnt = gate_en ? 1 : 0;
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b0);
            if (gate_en) cnt++;
            if (i == 3) check("R3 ce_out_n low inside window", ce_out_n, 1'b0);
        end
        check("R5 window length", logic'(cnt == W + 1), 1'b1);
        if (cnt != W + 1) $display("FAIL R5 window: actual=%0d expected=%0d", cnt, W + 1);
        check("R5 ce_out_n after expiry", ce_out_n, 1'b1);
        // R6: closed gate ignores the strobe
        for (int i = 0; i < 4; i++) begin
            step(1'b1, logic'(i % 2));
            check("R6 ce_out_n held high", ce_out_n, 1'b1);
            check("R6 gate_en held low", gate_en, 1'b0);
        end

        // R8: release with the strobe high, then low
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R8 ce_out_n stays high", ce_out_n, 1'b1);
        step(1'b0, 1'b0);
        check("R8 ce_out_n low with input low", ce_out_n, 1'b0);

        // R4: strobe raised inside the window
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check("R3 gate_en inside window", gate_en, 1'b1);
        step(1'b1, 1'b1);
        check("R4 ce_out_n high at once", ce_out_n, 1'b1);
        check("R4 gate_en before edge", gate_en, 1'b1);
        step(1'b1, 1'b0);
        check("R4 gate_en closed", gate_en, 1'b0);
        check("R4 ce_out_n stays high", ce_out_n, 1'b1);

        // R7: reset arrives with the strobe high
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        check("R7 gate_en closed without window", gate_en, 1'b0);
        check("R7 ce_out_n high", ce_out_n, 1'b1);

        // R9: release during the window keeps the gate open
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < W + 5; i++) step(1'b0, 1'b0);
        check("R9 gate_en still open", gate_en, 1'b1);
        check("R9 ce_out_n follows low", ce_out_n, 1'b0);

        // random phase against the bench model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic r;
            logic c;
            r = (($urandom % 40) == 0) ? ~sys_rst_active : sys_rst_active;
            c = (($urandom % 3) == 0) ? ~ce_in_n : ce_in_n;
            step(r, c);
            case (m_mode)
                0: begin
                    check("R6 random ce_out_n", ce_out_n, exp_out(ce_in_n));
                    check("R6 random gate_en", gate_en, exp_gate());
                end
                1: begin
                    check("R2 random ce_out_n", ce_out_n, exp_out(ce_in_n));
                    check("R8 random gate_en", gate_en, exp_gate());
                end
                default: begin
                    check("R3 random ce_out_n", ce_out_n, exp_out(ce_in_n));
                    check("R3 random gate_en", gate_en, exp_gate());
                end
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule